// File: doc/BRIEF.md
# Control endpoint stall register

This block is the device-mode control register of USB endpoint 0, the control endpoint. It holds two stall bits, one per direction. Software sets a stall bit to make the endpoint answer the host with a STALL handshake. The corresponding request output stays asserted until software clears the bit or a SETUP packet arrives. The register is 24 bits wide. Besides the stall bits it reports fixed fields: an enable bit per direction that always reads 1, and a type field per direction that always reads the control code 00.

The block also owns the endpoint's setup-status flag. A SETUP strobe from the packet layer sets the flag, and software clears it by writing 1 to a second register. While the flag is set, hardware forces both stall bits clear on every cycle, so a software write of 1 has no effect. When the flag is cleared, a down-counter loaded with `LOCKOUT_CYCLES` keeps the stall bits blocked for that many more cycles. Software writes take effect again only after the countdown ends.

The register port is a single-cycle port with a one-bit register select and a combinational read. Packet parsing and handshake generation belong to neighbouring logic. That logic reads the two STALL request outputs and supplies the SETUP strobe.

Top module: `ep0_stall_ctrl`

## Requirements
- R1: After reset the control register (select 0) reads 0x800080, both STALL request outputs are 0 and the setup-status flag is 0.
- R2: In the control register, bits 7 and 23 always read 1 and the type fields at bits 3:2 and 19:18 always read 00 (control). Bits 6:4, 15:8, 17 and 22:20 always read 0. Writes to any of these bits have no effect.
- R3: With no lockout active, a write to select 0 loads the receive stall from wdata bit 0 and the transmit stall from wdata bit 16. The new values are visible from the next cycle.
- R4: A stall bit holds its value until software writes it or a SETUP strobe arrives.
- R5: A SETUP strobe clears both stall bits in the following cycle.
- R6: The setup-status flag reads at bit 0 of select 1, and the other bits of select 1 read 0. A SETUP strobe sets the flag. A write to select 1 with wdata bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged. When a SETUP strobe and a clear arrive in the same cycle, the flag stays set.
- R7: While the setup-status flag is set, a write of 1 to either stall bit is ignored.
- R8: Suppose the flag is cleared by a write sampled at clock edge k. Stall writes sampled at edges k+1 through k+LOCKOUT_CYCLES are then ignored, and a write at edge k+LOCKOUT_CYCLES+1 takes effect. LOCKOUT_CYCLES is capped at 50.
- R9: A SETUP strobe during the post-release countdown sets the flag again. The next release restarts the full LOCKOUT_CYCLES window.
- R10: If a stall write of 1 and a SETUP strobe fall in the same cycle, the SETUP wins and both stall bits end up 0.
- R11: stall_rx_req and stall_tx_req equal the receive and transmit stall bits as read back at bits 0 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control register, 1 setup status |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for the selected register (combinational) |
| setup_rx | input | 1 | One-cycle strobe: SETUP packet received |
| setup_flag | output | 1 | Setup-status flag |
| stall_rx_req | output | 1 | Request STALL on the receive direction |
| stall_tx_req | output | 1 | Request STALL on the transmit direction |

## Verification
The read-back check writes every combination of the two stall bits with garbage in all other bit positions. This tells a correct fixed-field readback apart from one that lets written data leak into read-only or reserved bits. The lockout check sweeps the delay between the flag release and a stall write across every value from 1 to three cycles past the window. That sweep pins the exact edge where writes start to take effect, which catches off-by-one errors in either direction. A SETUP strobe is also applied mid-countdown, and SETUP, write and clear are applied in the same cycle. These patterns separate the restart rule and the priority rules from a design that only reacts to the first release.

// File: rtl/ep0_stall_pkg.sv
`timescale 1ns/1ps
package ep0_stall_pkg;
    localparam int REG_W        = 24;
    localparam int NUM_DIR      = 2;
    localparam int DIR_RX       = 0;
    localparam int DIR_TX       = 1;
    localparam int RX_STALL_BIT = 0;
    localparam int TX_STALL_BIT = 16;
    localparam int RX_EN_BIT    = 7;
    localparam int TX_EN_BIT    = 23;
    localparam int RX_TYPE_LSB  = 2;
    localparam int TX_TYPE_LSB  = 18;
    localparam int LOCK_MAX     = 50;

    typedef enum logic {
        SEL_EPCTRL    = 1'b0,
        SEL_SETUPSTAT = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        EPT_CONTROL   = 2'b00,
        EPT_ISOCH     = 2'b01,
        EPT_BULK      = 2'b10,
        EPT_INTERRUPT = 2'b11
    } ep_type_e;

    function automatic int stall_pos(input int dir);
        return (dir == DIR_RX) ? RX_STALL_BIT : TX_STALL_BIT;
    endfunction

    function automatic int enable_pos(input int dir);
        return (dir == DIR_RX) ? RX_EN_BIT : TX_EN_BIT;
    endfunction

    function automatic int type_lsb(input int dir);
        return (dir == DIR_RX) ? RX_TYPE_LSB : TX_TYPE_LSB;
    endfunction
endpackage

// File: rtl/ep0_setup_flag.sv
`timescale 1ns/1ps
module ep0_setup_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_rx,
    input  logic clr_req,
    output logic flag_q_o,
    output logic flag_fall_o
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (setup_rx) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q_o    = st_q.flag;
    assign flag_fall_o = st_q.flag & ~st_d.flag;

    a_r6_setup_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        setup_rx |=> flag_q_o)
        else $error("a_r6_setup_sets_flag");

    a_r6_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !setup_rx) |=> !flag_q_o)
        else $error("a_r6_clear_drops_flag");

    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !setup_rx) |=> $stable(flag_q_o))
        else $error("a_r6_flag_holds");
endmodule

// File: rtl/ep0_lockout_timer.sv
`timescale 1ns/1ps
module ep0_lockout_timer #(
    parameter int LOCKOUT_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_rx,
    input  logic flag_fall,
    output logic busy_o
);
    import ep0_stall_pkg::*;

    localparam int LOCK_EFF = (LOCKOUT_CYCLES > LOCK_MAX) ? LOCK_MAX :
                              ((LOCKOUT_CYCLES < 0) ? 0 : LOCKOUT_CYCLES);
    localparam int CW       = (LOCK_EFF < 1) ? 1 : $clog2(LOCK_EFF + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LOCK_EFF);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_fall) begin
            st_d.cnt = LOAD_VAL;
        end else if (setup_rx) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.cnt != '0);

    a_r8_load_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        flag_fall |=> (st_q.cnt == LOAD_VAL))
        else $error("a_r8_load_on_release");

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LOAD_VAL)
        else $error("a_r8_count_bounded");

    a_r9_setup_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_rx && !flag_fall) |=> (st_q.cnt == '0))
        else $error("a_r9_setup_restarts");
endmodule

// File: rtl/ep0_stall_bits.sv
`timescale 1ns/1ps
module ep0_stall_bits #(
    parameter int NUM_DIR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setup_rx,
    input  logic               lock_active,
    input  logic               wr_en,
    input  logic [NUM_DIR-1:0] wr_bits,
    output logic [NUM_DIR-1:0] stall_q_o
);
    typedef struct packed {
        logic [NUM_DIR-1:0] stall;
    } stall_state_t;

    stall_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (setup_rx || lock_active) begin
            st_d.stall = '0;
        end else if (wr_en) begin
            st_d.stall = wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_q_o = st_q.stall;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir_chk
        a_r5_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
            setup_rx |=> !stall_q_o[d])
            else $error("a_r5_setup_clears dir %0d", d);

        a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            lock_active |=> !stall_q_o[d])
            else $error("a_r7_lock_blocks dir %0d", d);

        a_r4_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!setup_rx && !lock_active && !wr_en) |=> $stable(stall_q_o[d]))
            else $error("a_r4_holds dir %0d", d);

        a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
            (!setup_rx && !lock_active && wr_en) |=> (stall_q_o[d] == $past(wr_bits[d])))
            else $error("a_r3_write_loads dir %0d", d);
    end
endmodule

// File: rtl/ep0_stall_ctrl.sv
`timescale 1ns/1ps
module ep0_stall_ctrl #(
    parameter int LOCKOUT_CYCLES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_sel,
    input  logic [23:0] reg_wdata,
    output logic [23:0] reg_rdata,
    input  logic        setup_rx,
    output logic        setup_flag,
    output logic        stall_rx_req,
    output logic        stall_tx_req
);
    import ep0_stall_pkg::*;

    logic               ctrl_wr;
    logic               stat_clr;
    logic               flag_q;
    logic               flag_fall;
    logic               timer_busy;
    logic               lock_active;
    logic [NUM_DIR-1:0] wr_bits;
    logic [NUM_DIR-1:0] stall_q;
    logic               wdata_unused;

    assign ctrl_wr     = reg_wr_en && (reg_sel == SEL_EPCTRL);
    assign stat_clr    = reg_wr_en && (reg_sel == SEL_SETUPSTAT) && reg_wdata[0];
    assign lock_active = flag_q || timer_busy;
    assign wdata_unused = ^{reg_wdata[23:17], reg_wdata[15:1]};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_wr_map
        assign wr_bits[d] = reg_wdata[stall_pos(d)];
    end

    ep0_setup_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_rx   (setup_rx),
        .clr_req    (stat_clr),
        .flag_q_o   (flag_q),
        .flag_fall_o(flag_fall)
    );

    ep0_lockout_timer #(
        .LOCKOUT_CYCLES(LOCKOUT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .setup_rx (setup_rx),
        .flag_fall(flag_fall),
        .busy_o   (timer_busy)
    );

    ep0_stall_bits #(
        .NUM_DIR(NUM_DIR)
    ) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_rx   (setup_rx),
        .lock_active(lock_active),
        .wr_en      (ctrl_wr),
        .wr_bits    (wr_bits),
        .stall_q_o  (stall_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_SETUPSTAT) begin
            reg_rdata[0] = flag_q;
        end else begin
            for (int d = 0; d < NUM_DIR; d++) begin
                reg_rdata[enable_pos(d)]                 = 1'b1;
                reg_rdata[type_lsb(d) +: 2]              = EPT_CONTROL;
                reg_rdata[stall_pos(d)]                  = stall_q[d];
            end
        end
    end

    assign setup_flag   = flag_q;
    assign stall_rx_req = stall_q[DIR_RX];
    assign stall_tx_req = stall_q[DIR_TX];

    a_r10_setup_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_rx && ctrl_wr) |=> (!stall_rx_req && !stall_tx_req && setup_flag))
        else $error("a_r10_setup_beats_write");

    a_r7_no_rise_while_flag: assert property (@(posedge clk) disable iff (!rst_n)
        setup_flag |=> (!stall_rx_req && !stall_tx_req))
        else $error("a_r7_no_rise_while_flag");
endmodule

// File: tb/ep0_stall_ctrl_tb.sv
`timescale 1ns/1ps
module ep0_stall_ctrl_tb;
    localparam int LOCK = 12;
    localparam logic [23:0] FIXED = 24'h800080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        setup_rx = 1'b0;
    logic        setup_flag;
    logic        stall_rx_req;
    logic        stall_tx_req;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ep0_stall_ctrl #(.LOCKOUT_CYCLES(LOCK)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .setup_rx    (setup_rx),
        .setup_flag  (setup_flag),
        .stall_rx_req(stall_rx_req),
        .stall_tx_req(stall_tx_req)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%06h expected=0x%06h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [23:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [23:0] data);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic setup_pulse();
        setup_rx = 1'b1;
        @(negedge clk);
        setup_rx = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_stalls(input string req, input logic rx, input logic tx);
        logic [23:0] v;
        chk({req, " outputs"}, {22'd0, stall_tx_req, stall_rx_req}, {22'd0, tx, rx});
        rd(1'b0, v);
        chk({req, " readback"}, v, FIXED | {7'd0, tx, 15'd0, rx});
    endtask

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v);
        chk("R1 ctrl reset value", v, FIXED);
        chk("R1 flag reset", {23'd0, setup_flag}, 24'd0);
        chk_stalls("R1", 1'b0, 1'b0);

        // R2 R3 R11: every stall combination with garbage in other bits
        for (int p = 0; p < 8; p++) begin
            logic rxb, txb;
            logic [23:0] junk;
            rxb  = p[0];
            txb  = p[1];
            junk = (p[2] ? 24'hFFFFFF : 24'h5A3C96) & ~24'h010001;
            wr(1'b0, junk | {7'd0, txb, 15'd0, rxb});
            chk_stalls("R2 R3 R11 write pattern", rxb, txb);
        end

        // R4 hold over idle cycles and unrelated select-1 writes
        wr(1'b0, 24'h010001);
        idle(7);
        wr(1'b1, 24'hFFFFFE);
        chk_stalls("R4 hold", 1'b1, 1'b1);

        // R5 R6 setup clears stalls, sets flag
        setup_pulse();
        chk_stalls("R5 setup clear", 1'b0, 1'b0);
        chk("R6 flag set by setup", {23'd0, setup_flag}, 24'd1);
        rd(1'b1, v);
        chk("R6 status readback", v, 24'd1);

        // R7 writes blocked while flag set
        for (int k = 0; k < 3; k++) begin
            wr(1'b0, 24'h010001);
            chk_stalls("R7 blocked under flag", 1'b0, 1'b0);
        end

        // R6 clear with bit0 = 0 has no effect
        wr(1'b1, 24'hFFFFFE);
        chk("R6 clear bit0=0 ignored", {23'd0, setup_flag}, 24'd1);

        // R8 sweep of write delay after release
        for (int j = 1; j <= LOCK + 3; j++) begin
            logic hon;
            setup_pulse();
            wr(1'b1, 24'h000001);
            chk("R6 flag cleared", {23'd0, setup_flag}, 24'd0);
            idle(j - 1);
            wr(1'b0, 24'h010001);
            hon = (j > LOCK);
            chk_stalls($sformatf("R8 delay %0d", j), hon, hon);
        end

        // R9 setup during countdown restarts the full window
        setup_pulse();
        wr(1'b1, 24'h000001);
        idle(3);
        setup_pulse();
        chk("R9 flag set again", {23'd0, setup_flag}, 24'd1);
        wr(1'b0, 24'h010001);
        chk_stalls("R9 blocked after re-setup", 1'b0, 1'b0);
        wr(1'b1, 24'h000001);
        idle(LOCK - 1);
        wr(1'b0, 24'h010001);
        chk_stalls("R9 last blocked edge", 1'b0, 1'b0);
        wr(1'b0, 24'h000001);
        chk_stalls("R9 first honoured edge", 1'b1, 1'b0);

        // R10 write and setup in the same cycle
        reg_wr_en = 1'b1;
        reg_sel   = 1'b0;
        reg_wdata = 24'h010001;
        setup_rx  = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        setup_rx  = 1'b0;
        chk_stalls("R10 setup wins over write", 1'b0, 1'b0);
        chk("R10 flag set", {23'd0, setup_flag}, 24'd1);

        // R6 clear and setup in the same cycle
        reg_wr_en = 1'b1;
        reg_sel   = 1'b1;
        reg_wdata = 24'h000001;
        setup_rx  = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        setup_rx  = 1'b0;
        chk("R6 setup wins over clear", {23'd0, setup_flag}, 24'd1);

        // R4 write 0 clears a set bit
        wr(1'b1, 24'h000001);
        idle(LOCK);
        wr(1'b0, 24'h010000);
        chk_stalls("R3 tx only", 1'b0, 1'b1);
        idle(5);
        chk_stalls("R4 tx held", 1'b0, 1'b1);
        wr(1'b0, 24'h000000);
        chk_stalls("R4 cleared by write 0", 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule